// File: doc/BRIEF.md
# Phase Fault and Thermal Flag Monitor

This block decides whether a synchronous buck power stage has a broken power switch or is running too hot. It drives a single shared fault pin that is active low. Three switch checks read comparator flags once per PWM period, each at a fixed settle delay after a PWM edge. The first check reads the "switch node far below the input rail" flag after a falling edge. The second reads the "switch node above ground" flag after a rising edge. The third reads the bottom-switch-open flag during the low-side on-time, also after a falling edge. Each check has its own run counter. A switch fault is declared only after a parameterised number of consecutive suspect samples, and once declared it stays latched until reset.

The thermal path takes two comparator flags: one above the rising threshold and one below the falling threshold. A hot condition must hold for a bounded qualification window before the pin is pulled. The pin is then held low until the cool flag is seen, which gives asymmetric hysteresis. The output pad is modelled as a drive-low enable together with the resulting pin level. All inputs are taken as already synchronous to `clk_i`.

Top module: `phase_fault_mon`

## Requirements
- R1: After reset, `flt_pull_o` is 0 and `flt_n_o` is 1.
- R2: The high-side check samples `sw_low_i` exactly SETTLE_CYC clocks after the clock edge on which a falling PWM edge (`pwm_i` 1 to 0) is seen. A sample of 1 is suspect and a sample of 0 is clean.
- R3: The low-side short check samples `sw_high_i` exactly SETTLE_CYC clocks after a rising PWM edge is seen, with the same suspect/clean meaning.
- R4: The bottom-open check samples `lo_open_i` at the same point as R2. It keeps its own run count, so it can declare a fault with no other flag active.
- R5: A switch fault is declared on the clock edge of the FAULT_RUN-th consecutive suspect sample of one check. FAULT_RUN-1 suspect samples alone do not declare it.
- R6: A clean sample resets that check's run count to zero.
- R7: A flag level that is present only during the first SETTLE_CYC-1 clocks after a PWM edge and gone at the sample point counts as clean.
- R8: A declared switch fault keeps `flt_pull_o` at 1 through any number of clean PWM cycles, until `rst_ni` is asserted.
- R9: The thermal path asserts after `temp_hot_i` has been 1 for THERM_DLY consecutive clocks. `flt_pull_o` is 1 after THERM_DLY rising edges and still 0 after THERM_DLY-1. A shorter hot pulse does not assert it and restarts the count.
- R10: Once asserted, the thermal indication holds while `temp_cool_i` is 0, even with `temp_hot_i` at 0. It clears on the first clock edge at which `temp_cool_i` is 1.
- R11: `flt_pull_o` is 1 when either the switch-fault path or the thermal path is active. `flt_n_o` is always its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM level (1 = high-side on) |
| sw_low_i | input | 1 | Switch node well below input rail |
| sw_high_i | input | 1 | Switch node above ground |
| lo_open_i | input | 1 | Bottom-switch-open comparator flag |
| temp_hot_i | input | 1 | Temperature above rising threshold |
| temp_cool_i | input | 1 | Temperature below falling threshold |
| flt_pull_o | output | 1 | Drive-low enable for the fault pad |
| flt_n_o | output | 1 | Fault pin level, active low |

## Verification
Several properties are checked on every cycle. A sample strobe fires only after PWM has been stable for the settle window. A switch fault only appears on a suspect sample and never clears without reset. A clean sample empties the run count. The thermal flag sets exactly when the hot run completes, and it clears or holds according to the cool flag. Other behaviour can only be shown by the bench scenarios: the exact count of consecutive cycles needed to declare a fault, run interruption by a clean cycle, independence of the three checks, rejection of ringing before the sample point, and the cycle at which the thermal flag reaches the pin.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int unsigned N_CHK = 3;
  typedef enum int unsigned {
    CHK_HS       = 0,  // node stays low after falling edge
    CHK_LS_SHORT = 1,  // node stays up after rising edge
    CHK_LS_OPEN  = 2   // bottom switch open during low-side on-time
  } chk_e;
endpackage

// File: rtl/pfm_edge_timer.sv
module pfm_edge_timer #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic samp_rise_o,
  output logic samp_fall_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          pwm_q, pend_rise_q, edge_s, strobe;
  logic [CW-1:0] cnt_q;

  assign edge_s = pwm_i ^ pwm_q;
  assign strobe = (cnt_q == ONE) && !edge_s;
  assign samp_rise_o = strobe && pend_rise_q;
  assign samp_fall_o = strobe && !pend_rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q       <= 1'b0;
      pend_rise_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      pwm_q <= pwm_i;
      if (edge_s) begin
        cnt_q       <= LOAD;
        pend_rise_q <= pwm_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  // independent stability counter for the settle check
  logic [CW-1:0] stab_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stab_q <= LOAD;
    else if (pwm_i != pwm_q) stab_q <= '0;
    else if (stab_q != LOAD) stab_q <= stab_q + ONE;
  end

  assert_settle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_rise_o || samp_fall_o) |-> (stab_q == CW'(SETTLE_CYC - 1)));
  assert_one_kind_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(samp_rise_o && samp_fall_o));
endmodule

// File: rtl/pfm_run_counter.sv
module pfm_run_counter #(
  parameter int unsigned FAULT_RUN = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic suspect_i,
  output logic fault_o
);
  localparam int unsigned RW = $clog2(FAULT_RUN + 1);
  localparam logic [RW-1:0] LAST = RW'(FAULT_RUN - 1);

  logic [RW-1:0] run_q;
  logic          fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      fault_q <= 1'b0;
    end else if (!fault_q && strobe_i) begin
      if (suspect_i) begin
        run_q <= run_q + RW'(1);
        if (run_q == LAST) fault_q <= 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  assign fault_o = fault_q;

  assert_latched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);
  assert_rise_on_suspect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o && !(strobe_i && suspect_i) |=> !fault_o);
  assert_clean_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && strobe_i && !suspect_i) |=> (run_q == '0));
endmodule

// File: rtl/pfm_thermal.sv
module pfm_thermal #(
  parameter int unsigned THERM_DLY = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic cool_i,
  output logic therm_o
);
  localparam int unsigned TW = $clog2(THERM_DLY + 1);
  localparam logic [TW-1:0] LAST = TW'(THERM_DLY - 1);

  logic [TW-1:0] cnt_q;
  logic          therm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      therm_q <= 1'b0;
    end else if (!therm_q) begin
      if (hot_i) begin
        if (cnt_q == LAST) begin
          therm_q <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end else if (cool_i) begin
      therm_q <= 1'b0;
    end
  end

  assign therm_o = therm_q;

  // independent run length of the hot flag while not flagged
  logic [TW-1:0] obs_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) obs_q <= '0;
    else if (therm_q || !hot_i) obs_q <= '0;
    else if (obs_q != LAST) obs_q <= obs_q + TW'(1);
  end

  assert_bounded_delay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!therm_o && hot_i && obs_q == LAST) |=> therm_o);
  assert_needs_hot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!therm_o && !hot_i) |=> !therm_o);
  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_o && cool_i) |=> !therm_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_o && !cool_i) |=> therm_o);
endmodule

// File: rtl/phase_fault_mon.sv
module phase_fault_mon #(
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned FAULT_RUN  = 15,
  parameter int unsigned THERM_DLY  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic sw_low_i,
  input  logic sw_high_i,
  input  logic lo_open_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  output logic flt_pull_o,
  output logic flt_n_o
);
  import pfm_pkg::*;

  logic samp_rise, samp_fall, therm;
  logic [N_CHK-1:0] stb, sus, flt;

  pfm_edge_timer #(.SETTLE_CYC(SETTLE_CYC)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i),
    .samp_rise_o(samp_rise), .samp_fall_o(samp_fall)
  );

  assign stb[CHK_HS]       = samp_fall;
  assign sus[CHK_HS]       = sw_low_i;
  assign stb[CHK_LS_SHORT] = samp_rise;
  assign sus[CHK_LS_SHORT] = sw_high_i;
  assign stb[CHK_LS_OPEN]  = samp_fall;
  assign sus[CHK_LS_OPEN]  = lo_open_i;

  for (genvar g = 0; g < N_CHK; g++) begin : g_chk
    pfm_run_counter #(.FAULT_RUN(FAULT_RUN)) u_run (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .strobe_i(stb[g]), .suspect_i(sus[g]), .fault_o(flt[g])
    );
  end

  pfm_thermal #(.THERM_DLY(THERM_DLY)) u_therm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hot_i(temp_hot_i), .cool_i(temp_cool_i), .therm_o(therm)
  );

  assign flt_pull_o = (|flt) | therm;
  assign flt_n_o    = ~flt_pull_o;

  assert_therm_pulls_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm |-> !flt_n_o);
  assert_sw_pulls_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flt) |-> flt_pull_o);
endmodule

// File: tb/sim_phase_fault_mon.sv
module sim_phase_fault_mon;
  localparam int unsigned SETTLE = 4;
  localparam int unsigned RUN    = 15;
  localparam int unsigned TDLY   = 32;
  localparam int unsigned PHASE  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm = 0, sw_low = 0, sw_high = 0, lo_open = 0, hot = 0, cool = 0;
  logic pull, pin_n;

  always #10 clk = ~clk;

  phase_fault_mon #(.SETTLE_CYC(SETTLE), .FAULT_RUN(RUN), .THERM_DLY(TDLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .sw_low_i(sw_low),
    .sw_high_i(sw_high), .lo_open_i(lo_open), .temp_hot_i(hot),
    .temp_cool_i(cool), .flt_pull_o(pull), .flt_n_o(pin_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit    exp_q[$];
  string tag_q[$];

  // bench model
  int run_m[3];
  bit latch_m, therm_m;

  task automatic push(input string tag);
    exp_q.push_back(latch_m | therm_m);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (pull !== e || pin_n !== !e) begin
          n_fail++;
          $display("FAIL %s: pull=%0b pin_n=%0b expected pull=%0b pin_n=%0b", t, pull, pin_n, e, !e);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pwm = 0; sw_low = 0; sw_high = 0; lo_open = 0; hot = 0; cool = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    foreach (run_m[i]) run_m[i] = 0;
    latch_m = 0; therm_m = 0;
    @(negedge clk);
    push("R1");
  endtask

  task automatic model_sample(input int idx, input bit s);
    if (s) run_m[idx]++; else run_m[idx] = 0;
    if (run_m[idx] >= RUN) latch_m = 1;
  endtask

  // one PWM period: high phase then low phase
  task automatic pwm_cycle(input bit lo_s, input bit hi_s, input bit op_s,
                           input bit glitch, input string tag);
    pwm = 1; sw_high = hi_s; sw_low = 0; lo_open = 0;
    repeat (PHASE) @(negedge clk);
    pwm = 0; sw_high = 0; lo_open = op_s;
    for (int i = 0; i < PHASE; i++) begin
      sw_low = glitch ? (i < SETTLE - 1) : lo_s;
      @(negedge clk);
    end
    sw_low = 0; lo_open = 0;
    model_sample(1, hi_s);
    model_sample(0, glitch ? 1'b0 : lo_s);
    model_sample(2, op_s);
    push(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();                                         // R1
    repeat (3) pwm_cycle(0, 0, 0, 0, "R5 clean");
    // R2/R5: high-side run
    repeat (RUN - 1) pwm_cycle(1, 0, 0, 0, "R5 below run");
    pwm_cycle(1, 0, 0, 0, "R2 R5 run complete");
    // R8: latched
    repeat (3) pwm_cycle(0, 0, 0, 0, "R8 latched");
    do_reset();
    // R3/R6: low-side short run broken by clean cycle
    repeat (RUN - 1) pwm_cycle(0, 1, 0, 0, "R3 below run");
    pwm_cycle(0, 0, 0, 0, "R6 clean breaks run");
    repeat (RUN - 1) pwm_cycle(0, 1, 0, 0, "R6 restarted run");
    pwm_cycle(0, 1, 0, 0, "R3 run complete");
    do_reset();
    // R4: bottom-open alone, with alternating high-side suspects that never run
    for (int i = 0; i < RUN; i++) pwm_cycle(i % 2, 0, 1, 0, "R4 open run");
    do_reset();
    // R7: ringing before sample point is clean
    repeat (RUN - 1) pwm_cycle(1, 0, 0, 0, "R7 pre");
    pwm_cycle(0, 0, 0, 1, "R7 ringing ignored");
    pwm_cycle(1, 0, 0, 0, "R7 run restarted");
    do_reset();
    // R9: short hot pulse
    hot = 1;
    repeat (TDLY - 1) @(negedge clk);
    hot = 0;
    push("R9 short pulse");
    repeat (TDLY) @(negedge clk);
    push("R9 after short pulse");
    // R9: full qualification
    hot = 1;
    repeat (TDLY - 1) @(negedge clk);
    push("R9 one short of delay");
    @(negedge clk);
    therm_m = 1;
    push("R9 R11 thermal pulls");
    // R10: hysteresis
    hot = 0;
    repeat (5) @(negedge clk);
    push("R10 hold while warm");
    cool = 1;
    @(negedge clk);
    therm_m = 0;
    push("R10 release on cool");
    cool = 0;
    repeat (3) @(negedge clk);
    push("R10 stays released");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule